// File: doc/BRIEF.md
# ECC-Guarded Word Memory with Background Scrub

This block puts a single-error-correct, double-error-detect code around a 32-bit-wide on-chip memory. It serves a processor through one simple request port: address, write data and byte enables go in, and corrected read data comes back. Each stored word carries seven check bits, so every 39-bit row is protected as a whole. Full-word reads and writes run at the memory's own speed. A write of one byte or one halfword is turned into a hidden read, merge and re-encode, so the check bits always describe the complete word.

A background scrubber uses idle cycles. It reads one row at a programmable spacing, writes the corrected word back when it finds a single flipped bit, and leaves a word alone when it cannot correct it. Corrections are counted and the last corrected address is kept. An uncorrectable word sets a sticky flag and records its address. That flag drives an interrupt output and a fault output, each with its own enable. A mask input can flip chosen stored bits on processor writes, so that the error paths can be exercised in place.

Top module: `eccMemGuard`

## Requirements
- R1: Each word is stored as a 39-bit codeword: 32 data bits, a 6-bit Hamming check and one overall parity bit. Any single flipped bit in a stored word is corrected on read. Read data is valid in the cycle after the request is accepted.
- R2: A request is accepted on a rising edge where `req` and `ready` are both high. A full-word write (`be` = 4'b1111) or a read never lowers `ready` in the following cycle.
- R3: A write with `be` other than 4'b1111 merges the selected bytes into the stored word, where `be[i]` selects bits 8i+7..8i. `ready` is low for exactly the one cycle after acceptance.
- R4: A processor read that hits a single-bit error returns corrected data, adds one to `corrCount` and latches the address in `corrAddr`. The stored word is not rewritten, so a repeated read counts again.
- R5: `corrCount` saturates at 2^CNT_W-1.
- R6: A double-bit error found by a read, a merge or a scrub sets `errValid` and latches the address in `errAddr`.
- R7: `irq` equals `errValid` AND `irqEn`, and `fault` equals `errValid` AND `faultEn`, each enable acting independently.
- R8: `errValid` stays set until a cycle with `errClr` high clears it. A new uncorrectable error in the same cycle wins over the clear.
- R9: When `scrubInterval` is N (nonzero), a scrub slot becomes due every N cycles. The scrubber writes corrected words back and counts each correction in `corrCount` and `corrAddr`. N = 0 stops scrubbing.
- R10: A scrub slot starts only in a cycle with no processor request, so a continuous request stream keeps `ready` high. The scrub address advances once per granted slot and wraps from the last row to row 0.
- R11: An uncorrectable word is never written: a scrub leaves it as it is, and a sub-word write to it is dropped and reported.
- R12: On processor writes, `injFlip` is XORed into the stored codeword. A zero mask stores a clean word.
- R13: After reset, `ready` = 1, `corrCount` = 0, `errValid` = 0, and `irq` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables for writes |
| rdata | output | 32 | Corrected read data, valid in the cycle after acceptance |
| ready | output | 1 | Block can accept a request this cycle |
| injFlip | input | 39 | Codeword bit-flip mask applied on processor writes |
| scrubInterval | input | IVL_W | Cycles between scrub slots, 0 = off |
| irqEn | input | 1 | Interrupt enable for uncorrectable errors |
| faultEn | input | 1 | Fault enable for uncorrectable errors |
| errClr | input | 1 | Clears the sticky uncorrectable flag |
| corrCount | output | CNT_W | Saturating count of corrected errors |
| corrAddr | output | ADDR_W | Address of the last corrected error |
| errValid | output | 1 | Sticky uncorrectable-error flag |
| errAddr | output | ADDR_W | Address of the last uncorrectable error |
| irq | output | 1 | Interrupt request |
| fault | output | 1 | Fault request |

## Verification
A wrong stall state shows up at once as `ready` being low in a cycle after a full access, or high in the cycle after a sub-word write. A wrong merge or a wrong code appears in the first read-back after the write. A scrub pointer that stalls or skips leaves a planted single-bit error uncounted, and that shows in `corrCount` and in a later read that still counts. A scrub that rewrites a damaged word would make the next read of that row clean, where it should still raise `errValid`, and a counter that fails to saturate wraps to a small value after a long run of failing reads.

// File: rtl/eccPkg.sv
package eccPkg;
  localparam int CODE_W = 39;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {SRC_PROC, SRC_MERGE, SRC_FIX} wrSrc_e;

  typedef struct packed {
    logic   rdEn;
    logic   wrEn;
    wrSrc_e wrSrc;
    logic   inj;
    logic   capture;
  } memStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sgl;
    logic              dbl;
  } decode_t;

  // Codeword layout: bit 0 = overall parity, bits at powers of two = Hamming
  // checks, every other position 1..38 carries data in ascending order.
  function automatic logic [CODE_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] cw;
    logic par;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < 6; i++) begin
      par = 1'b0;
      for (int p = 1; p < CODE_W; p++)
        if (((p >> i) & 1) == 1) par = par ^ cw[p];
      cw[1 << i] = par;
    end
    cw[0] = ^cw[CODE_W-1:1];
    return cw;
  endfunction

  function automatic decode_t eccDecode(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] cw;
    logic [5:0] syn;
    logic parErr;
    decode_t r;
    int k;
    cw = code;
    for (int i = 0; i < 6; i++) begin
      syn[i] = 1'b0;
      for (int p = 1; p < CODE_W; p++)
        if (((p >> i) & 1) == 1) syn[i] = syn[i] ^ cw[p];
    end
    parErr = ^cw;
    r.sgl = 1'b0;
    r.dbl = 1'b0;
    if (parErr) begin
      if (int'(syn) < CODE_W) begin
        cw[syn] = ~cw[syn];
        r.sgl = 1'b1;
      end else begin
        r.dbl = 1'b1;
      end
    end else if (syn != 6'd0) begin
      r.dbl = 1'b1;
    end
    r.data = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r.data[k] = cw[p];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/eccDatapath.sv
module eccDatapath
  import eccPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  memStrobe_t          strb,
  input  logic [ADDR_W-1:0]   memAddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [3:0]          be,
  input  logic [CODE_W-1:0]   injFlip,
  output logic [DATA_W-1:0]   rdata,
  output logic                sglErr,
  output logic                dblErr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BYTES = DATA_W / 8;

  logic [CODE_W-1:0] mem [DEPTH];
  logic [CODE_W-1:0] rdCode;
  logic [DATA_W-1:0] savedData;
  logic [BYTES-1:0]  savedBe;
  logic [DATA_W-1:0] mergedData;
  logic [DATA_W-1:0] wrData;
  logic [CODE_W-1:0] wrCode;
  decode_t           dec;

  assign dec    = eccDecode(rdCode);
  assign rdata  = dec.data;
  assign sglErr = dec.sgl;
  assign dblErr = dec.dbl;

  for (genvar b = 0; b < BYTES; b++) begin : gMerge
    assign mergedData[8*b +: 8] = savedBe[b] ? savedData[8*b +: 8] : dec.data[8*b +: 8];
  end

  always_comb begin
    unique case (strb.wrSrc)
      SRC_MERGE: wrData = mergedData;
      SRC_FIX:   wrData = dec.data;
      default:   wrData = wdata;
    endcase
    wrCode = eccEncode(wrData) ^ (strb.inj ? injFlip : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCode    <= '0;
      savedData <= '0;
      savedBe   <= '0;
    end else begin
      if (strb.rdEn) rdCode <= mem[memAddr];
      if (strb.capture) begin
        savedData <= wdata;
        savedBe   <= be;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[memAddr] <= wrCode;
  end

  // R11: a scrub write-back only ever carries a corrected single-error word
  assert_fix_only_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrSrc == SRC_FIX) |-> (sglErr && !dblErr));
  // R11: a merge write never lands on an uncorrectable word
  assert_merge_not_double_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrSrc == SRC_MERGE) |-> !dblErr);
endmodule

// File: rtl/eccControl.sv
module eccControl
  import eccPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [3:0]        be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IVL_W-1:0]  scrubInterval,
  input  logic              irqEn,
  input  logic              faultEn,
  input  logic              errClr,
  input  logic              sglErr,
  input  logic              dblErr,
  output memStrobe_t        strb,
  output logic [ADDR_W-1:0] memAddr,
  output logic              ready,
  output logic [CNT_W-1:0]  corrCount,
  output logic [ADDR_W-1:0] corrAddr,
  output logic              errValid,
  output logic [ADDR_W-1:0] errAddr,
  output logic              irq,
  output logic              fault
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_RMW, ST_SCRUB} state_e;

  state_e            state, nextState;
  logic [ADDR_W-1:0] savedAddr, scrubPtr;
  logic [IVL_W-1:0]  timer;
  logic              pend, rdTag;
  logic              accept, partial, grant, checkNow, sglHit, dblHit;

  assign ready    = (state == ST_IDLE);
  assign accept   = ready && req;
  assign partial  = we && (be != 4'b1111);
  assign grant    = ready && !req && pend;
  assign checkNow = rdTag || (state != ST_IDLE);
  assign sglHit   = checkNow && sglErr;
  assign dblHit   = checkNow && dblErr;
  assign irq      = errValid && irqEn;
  assign fault    = errValid && faultEn;

  always_comb begin
    strb      = '0;
    memAddr   = addr;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (we && !partial) begin
            strb.wrEn  = 1'b1;
            strb.wrSrc = SRC_PROC;
            strb.inj   = 1'b1;
          end else begin
            strb.rdEn    = 1'b1;
            strb.capture = we;
            if (we) nextState = ST_RMW;
          end
        end else if (grant) begin
          strb.rdEn = 1'b1;
          memAddr   = scrubPtr;
          nextState = ST_SCRUB;
        end
      end
      ST_RMW: begin
        memAddr    = savedAddr;
        strb.wrEn  = !dblErr;
        strb.wrSrc = SRC_MERGE;
        strb.inj   = 1'b1;
        nextState  = ST_IDLE;
      end
      default: begin
        memAddr    = savedAddr;
        strb.wrEn  = sglErr;
        strb.wrSrc = SRC_FIX;
        nextState  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      savedAddr <= '0;
      scrubPtr  <= '0;
      timer     <= '0;
      pend      <= 1'b0;
      rdTag     <= 1'b0;
      corrCount <= '0;
      corrAddr  <= '0;
      errValid  <= 1'b0;
      errAddr   <= '0;
    end else begin
      state <= nextState;
      rdTag <= accept && !we;
      if (strb.rdEn) savedAddr <= memAddr;
      if (grant) scrubPtr <= scrubPtr + 1'b1;
      if (scrubInterval == '0) begin
        timer <= '0;
        pend  <= 1'b0;
      end else if (grant) begin
        timer <= '0;
        pend  <= 1'b0;
      end else if (!pend) begin
        if (timer >= scrubInterval - 1'b1) begin
          pend  <= 1'b1;
          timer <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
      end
      if (sglHit) begin
        corrAddr <= savedAddr;
        if (corrCount != MAXC) corrCount <= corrCount + 1'b1;
      end
      if (dblHit) begin
        errValid <= 1'b1;
        errAddr  <= savedAddr;
      end else if (errClr) begin
        errValid <= 1'b0;
      end
    end
  end

  assert_full_no_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !partial) |=> ready);
  assert_partial_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && partial) |=> !ready);
  assert_stall_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ready);
  assert_ptr_on_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(scrubPtr) |-> $past(grant));
  assert_count_saturates_R5: assert property (@(posedge clk) disable iff (!rstN)
    (corrCount == MAXC) |=> (corrCount == MAXC));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !errClr) |=> errValid);
endmodule

// File: rtl/eccMemGuard.sv
module eccMemGuard
  import eccPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int IVL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [31:0]       rdata,
  output logic              ready,
  input  logic [38:0]       injFlip,
  input  logic [IVL_W-1:0]  scrubInterval,
  input  logic              irqEn,
  input  logic              faultEn,
  input  logic              errClr,
  output logic [CNT_W-1:0]  corrCount,
  output logic [ADDR_W-1:0] corrAddr,
  output logic              errValid,
  output logic [ADDR_W-1:0] errAddr,
  output logic              irq,
  output logic              fault
);
  memStrobe_t        strb;
  logic [ADDR_W-1:0] memAddr;
  logic              sglErr, dblErr;

  eccControl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IVL_W(IVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .be(be), .addr(addr),
    .scrubInterval(scrubInterval), .irqEn(irqEn), .faultEn(faultEn),
    .errClr(errClr), .sglErr(sglErr), .dblErr(dblErr), .strb(strb),
    .memAddr(memAddr), .ready(ready), .corrCount(corrCount),
    .corrAddr(corrAddr), .errValid(errValid), .errAddr(errAddr),
    .irq(irq), .fault(fault)
  );

  eccDatapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .memAddr(memAddr), .wdata(wdata),
    .be(be), .injFlip(injFlip), .rdata(rdata), .sglErr(sglErr), .dblErr(dblErr)
  );
endmodule

// File: tb/sim_eccMemGuard.sv
module sim_eccMemGuard;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0]  a;
    logic [3:0]  be;
    logic [31:0] exp;
  } vec_t;

  localparam logic [31:0] BASE = 32'h11223344;
  localparam logic [31:0] NEWD = 32'hAABBCCDD;
  localparam vec_t [0:6] VEC = '{
    '{6'd1, 4'b0001, 32'h112233DD},
    '{6'd2, 4'b0010, 32'h1122CC44},
    '{6'd3, 4'b0100, 32'h11BB3344},
    '{6'd4, 4'b1000, 32'hAA223344},
    '{6'd5, 4'b1100, 32'hAABB3344},
    '{6'd6, 4'b0011, 32'h1122CCDD},
    '{6'd7, 4'b1111, 32'hAABBCCDD}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic req = 1'b0, we = 1'b0, irqEn = 1'b0, faultEn = 1'b0, errClr = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] be = 4'hF;
  logic [38:0] injFlip = '0;
  logic [15:0] scrubInterval = '0;
  logic ready, errValid, irq, fault;
  logic [7:0] corrCount;
  logic [5:0] corrAddr, errAddr;
  int checks = 0, errors = 0;
  int expCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eccMemGuard u0 (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .be(be), .rdata(rdata), .ready(ready), .injFlip(injFlip),
    .scrubInterval(scrubInterval), .irqEn(irqEn), .faultEn(faultEn),
    .errClr(errClr), .corrCount(corrCount), .corrAddr(corrAddr),
    .errValid(errValid), .errAddr(errAddr), .irq(irq), .fault(fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [31:0] d,
                         input logic [3:0] b, input logic [38:0] m);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b; injFlip = m;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0; injFlip = '0;
  endtask

  task automatic doRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic clearErr();
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R13 ready", 32'(ready), 32'd1);
    chk("R13 corrCount", 32'(corrCount), 32'd0);
    chk("R13 errValid", 32'(errValid), 32'd0);
    chk("R13 irq/fault", {30'd0, irq, fault}, 32'd0);

    // R2 / R3 / R1: merge table
    for (int i = 0; i < 7; i++) begin
      doWrite(VEC[i].a, BASE, 4'b1111, '0);
      chk("R2 ready after full write", 32'(ready), 32'd1);
      doWrite(VEC[i].a, NEWD, VEC[i].be, '0);
      chk((VEC[i].be == 4'b1111) ? "R2 ready after full write" : "R3 stall after partial",
          32'(ready), (VEC[i].be == 4'b1111) ? 32'd1 : 32'd0);
      doRead(VEC[i].a, d);
      chk("R3 merge result", d, VEC[i].exp);
      chk("R2 ready after read", 32'(ready), 32'd1);
    end
    @(negedge clk);
    chk("R12 clean writes no corrections", 32'(corrCount), 32'd0);

    // R4 / R12 / R1: single flips in data, overall parity and top position
    doWrite(6'd10, 32'hDEADBEEF, 4'hF, 39'h1 << 5);
    doRead(6'd10, d);
    chk("R1 R4 corrected data", d, 32'hDEADBEEF);
    @(negedge clk);
    expCnt = 1;
    chk("R4 count", 32'(corrCount), 32'(expCnt));
    chk("R4 corrAddr", 32'(corrAddr), 32'd10);
    doRead(6'd10, d);
    @(negedge clk);
    expCnt = 2;
    chk("R4 no write-back on read", 32'(corrCount), 32'(expCnt));
    doWrite(6'd11, 32'h0F0F1234, 4'hF, 39'h1);
    doRead(6'd11, d);
    chk("R1 parity bit flip corrected", d, 32'h0F0F1234);
    doWrite(6'd12, 32'h80000001, 4'hF, 39'h1 << 38);
    doRead(6'd12, d);
    chk("R1 top bit flip corrected", d, 32'h80000001);
    @(negedge clk);
    expCnt = 4;
    chk("R4 count", 32'(corrCount), 32'(expCnt));
    chk("R4 corrAddr", 32'(corrAddr), 32'd12);

    // R6 / R7: double flip
    irqEn = 1'b1;
    doWrite(6'd20, 32'h55AA55AA, 4'hF, (39'h1 << 3) | (39'h1 << 17));
    doRead(6'd20, d);
    @(negedge clk);
    chk("R6 errValid", 32'(errValid), 32'd1);
    chk("R6 errAddr", 32'(errAddr), 32'd20);
    chk("R6 no count", 32'(corrCount), 32'(expCnt));
    chk("R7 irq on fault off", {30'd0, irq, fault}, 32'd2);
    faultEn = 1'b1; irqEn = 1'b0;
    #1;
    chk("R7 irq off fault on", {30'd0, irq, fault}, 32'd1);

    // R8: clear
    clearErr();
    chk("R8 cleared", 32'(errValid), 32'd0);
    chk("R8 fault dropped", 32'(fault), 32'd0);

    // R11: sub-word write on uncorrectable word is dropped and reported
    doWrite(6'd20, 32'h000000FF, 4'b0001, '0);
    @(negedge clk);
    chk("R11 RMW reports double", 32'(errValid), 32'd1);
    chk("R11 RMW errAddr", 32'(errAddr), 32'd20);
    clearErr();
    doRead(6'd20, d);
    @(negedge clk);
    chk("R11 RMW write dropped", 32'(errValid), 32'd1);
    clearErr();

    // R9: scrub pass fixes singles at 0,10,11,12,30,63
    doWrite(6'd30, 32'h30303030, 4'hF, 39'h1 << 9);
    doWrite(6'd63, 32'h63636363, 4'hF, 39'h1 << 33);
    doWrite(6'd0,  32'h00C0FFEE, 4'hF, 39'h1 << 1);
    @(negedge clk); scrubInterval = 16'd2;
    repeat (500) @(negedge clk);
    scrubInterval = 16'd0;
    repeat (3) @(negedge clk);
    expCnt = 10;
    chk("R9 scrub counted corrections", 32'(corrCount), 32'(expCnt));
    chk("R9 scrub corrAddr", 32'(corrAddr), 32'd63);
    chk("R11 scrub saw double", 32'(errValid), 32'd1);
    chk("R11 scrub errAddr", 32'(errAddr), 32'd20);
    doRead(6'd30, d);
    chk("R9 scrubbed data", d, 32'h30303030);
    @(negedge clk);
    chk("R9 word written back", 32'(corrCount), 32'(expCnt));
    clearErr();
    doRead(6'd20, d);
    @(negedge clk);
    chk("R11 scrub left double word", 32'(errValid), 32'd1);
    clearErr();
    faultEn = 1'b0;

    // R10: continuous requests hold off scrub
    @(negedge clk);
    scrubInterval = 16'd1; req = 1'b1; we = 1'b0; addr = 6'd5;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      chk("R10 scrub yields", 32'(ready), 32'd1);
      @(negedge clk);
    end
    req = 1'b0;

    // R10: wrap, rows 0 and 5 repaired on a later pass
    scrubInterval = 16'd0;
    repeat (3) @(negedge clk);
    doWrite(6'd0, 32'h0BADF00D, 4'hF, 39'h1 << 20);
    doWrite(6'd5, 32'h5A5A5A5A, 4'hF, 39'h1 << 2);
    @(negedge clk); scrubInterval = 16'd2;
    repeat (500) @(negedge clk);
    scrubInterval = 16'd0;
    repeat (3) @(negedge clk);
    expCnt = 12;
    chk("R10 wrap repaired both", 32'(corrCount), 32'(expCnt));
    doRead(6'd0, d);
    chk("R10 row 0 data", d, 32'h0BADF00D);
    clearErr();

    // R5: saturation with a streaming read of a damaged word
    doWrite(6'd10, 32'h12345678, 4'hF, 39'h1 << 24);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 6'd10;
    repeat (260) @(negedge clk);
    req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 saturated", 32'(corrCount), 32'd255);
    doRead(6'd10, d);
    @(negedge clk);
    chk("R5 stays saturated", 32'(corrCount), 32'd255);
    chk("R4 data still corrected", d, 32'h12345678);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule